// File: doc/BRIEF.md
# Strided Vector Load Unit

This block reads one vector out of a word-interleaved memory with sixteen banks and hands the elements to a vector register file. A caller supplies a starting word address, a stride and an element count. On the next cycle the block begins stepping through the addresses base, base + stride, base + 2·stride and so on. It has a single address generator, so at most one bank access can start per cycle. The low four address bits choose the bank.

Each bank stays occupied for a fixed eleven cycles after an access starts. The block keeps one countdown timer per bank. If the next element maps to a bank whose timer is still running, the stream waits, and element order is kept.

A unit stride touches sixteen distinct banks before it comes back to the first one. That is more than the eleven-cycle occupancy, so a unit-stride stream issues every cycle. Strides such as 2, 16 or 0 revisit banks sooner and throttle the stream. Each element's read data is written back to register slot i with a strobe. A one-cycle done pulse follows the last write.

Top module: `strided_vload`

## Requirements
- R1: Element i is requested on `mem_addr` with address base + i·stride (modulo 2^32), in increasing i. The requested bank is `mem_addr[3:0]`.
- R2: `mem_req` is high in at most one cycle per element. Element 0 is requested in the cycle after `start` is accepted. With stride 1, the elements are requested in consecutive cycles.
- R3: A request to a bank is not made earlier than 11 cycles after the previous request to that same bank. Otherwise each element is requested as early as this rule and the one-per-cycle order allow.
- R4: The data present on `mem_rdata` in the cycle an element is requested appears on `wr_data` exactly 11 cycles later. In that cycle `wr_valid` is high and `wr_idx` equals the element index.
- R5: Write-backs arrive in element order 0, 1, …, n−1, at most one per cycle.
- R6: A `vlen` value above 64 is treated as 64.
- R7: `done` is high for one cycle, in the cycle after the last write-back. `busy` is high from the cycle after `start` until the last write-back cycle, and low in the `done` cycle.
- R8: With `vlen` = 0, `done` is high in the cycle after `start` and no request is made.
- R9: A `start` while `busy` is high is ignored. The running transfer's addresses, timing and data are unchanged.
- R10: After reset, `busy`, `mem_req`, `wr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when not busy) |
| base_addr | input | 32 | Word address of element 0 |
| stride | input | 32 | Word distance between elements (two's complement) |
| vlen | input | 7 | Element count, saturated at 64 |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | A bank access starts this cycle |
| mem_addr | output | 32 | Word address of the access |
| mem_rdata | input | 32 | Read data for `mem_addr`, valid in the request cycle |
| wr_valid | output | 1 | Register write strobe |
| wr_idx | output | 6 | Register element index |
| wr_data | output | 32 | Register write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a stream that mixes free and busy banks. In that case some elements issue back to back and others wait a few cycles, so an off-by-one in the bank timer shows up only as a one-cycle shift in a later element.

The bench drives strides of 1, 2, 16, 0 and −1, and a saturated length. It runs an independent model of per-bank free times and checks every request and write-back cycle exactly. One run also injects a second start partway through the stream.

// File: rtl/vload_pkg.sv
package vload_pkg;
    parameter int VL_NUM_BANKS = 16;
    parameter int VL_BANK_LAT  = 11;
    parameter int VL_MAX_LEN   = 64;
    parameter int VL_ADDR_W    = 32;
    parameter int VL_DATA_W    = 32;
endpackage

// File: rtl/vl_bank_timer.sv
module vl_bank_timer #(
    parameter int LAT    = vload_pkg::VL_BANK_LAT,
    parameter int IDX_W  = 6,
    parameter int DATA_W = vload_pkg::VL_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_en,
    input  logic [IDX_W-1:0]  issue_idx,
    input  logic [DATA_W-1:0] issue_data,
    output logic              free,
    output logic              complete,
    output logic [IDX_W-1:0]  cmp_idx,
    output logic [DATA_W-1:0] cmp_data
);
    localparam int CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.cnt != '0) begin
            slot_d.cnt = slot_q.cnt - 1'b1;
        end
        if (issue_en) begin
            slot_d.cnt  = CNT_W'(LAT - 1);
            slot_d.idx  = issue_idx;
            slot_d.data = issue_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign free     = (slot_q.cnt == '0);
    assign complete = (slot_q.cnt == CNT_W'(1));
    assign cmp_idx  = slot_q.idx;
    assign cmp_data = slot_q.data;

    initial assert (LAT >= 2) else $error("bank latency must be at least 2");

    // R3: a new access never lands on a bank whose timer is running
    assert_issue_free_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> free);

    // R4: a started access holds the bank in the following cycle
    assert_busy_after_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |=> !free);
endmodule

// File: rtl/vl_addr_gen.sv
module vl_addr_gen #(
    parameter int ADDR_W = vload_pkg::VL_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] stride;
    } ag_t;

    ag_t ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        if (load) begin
            ag_d.addr   = base;
            ag_d.stride = stride;
        end else if (step) begin
            ag_d.addr = ag_q.addr + ag_q.stride;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ag_q <= '0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign addr = ag_q.addr;

    // R1: consecutive elements are one stride apart
    assert_stride_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (ag_q.addr == $past(ag_q.addr) + $past(ag_q.stride)));
endmodule

// File: rtl/strided_vload.sv
module strided_vload #(
    parameter int NUM_BANKS = vload_pkg::VL_NUM_BANKS,
    parameter int BANK_LAT  = vload_pkg::VL_BANK_LAT,
    parameter int MAX_LEN   = vload_pkg::VL_MAX_LEN,
    parameter int ADDR_W    = vload_pkg::VL_ADDR_W,
    parameter int DATA_W    = vload_pkg::VL_DATA_W,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(MAX_LEN),
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [LEN_W-1:0]  vlen,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_valid,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);
    typedef struct packed {
        logic              active;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  issued;
        logic [LEN_W-1:0]  left;
        logic              wr_valid;
        logic [IDX_W-1:0]  wr_idx;
        logic [DATA_W-1:0] wr_data;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 start_ok;
    logic                 issue;
    logic [LEN_W-1:0]     eff_len;
    logic [BANK_W-1:0]    bank_sel;
    logic [NUM_BANKS-1:0] bank_free;
    logic [NUM_BANKS-1:0] bank_issue;
    logic [NUM_BANKS-1:0] bank_cmp;
    logic [IDX_W-1:0]     cmp_idx  [NUM_BANKS];
    logic [DATA_W-1:0]    cmp_data [NUM_BANKS];

    assign start_ok = start && !ctl_q.active;
    assign eff_len  = (vlen > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : vlen;
    assign bank_sel = mem_addr[BANK_W-1:0];
    assign issue    = ctl_q.active && (ctl_q.issued < ctl_q.len) && bank_free[bank_sel];

    vl_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_ok),
        .step   (issue),
        .base   (base_addr),
        .stride (stride),
        .addr   (mem_addr)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign bank_issue[g] = issue && (bank_sel == BANK_W'(g));
        vl_bank_timer #(.LAT(BANK_LAT), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_timer (
            .clk        (clk),
            .rst_n      (rst_n),
            .issue_en   (bank_issue[g]),
            .issue_idx  (ctl_q.issued[IDX_W-1:0]),
            .issue_data (mem_rdata),
            .free       (bank_free[g]),
            .complete   (bank_cmp[g]),
            .cmp_idx    (cmp_idx[g]),
            .cmp_data   (cmp_data[g])
        );
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.wr_valid = 1'b0;
        ctl_d.done     = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_cmp[b]) begin
                ctl_d.wr_valid = 1'b1;
                ctl_d.wr_idx   = cmp_idx[b];
                ctl_d.wr_data  = cmp_data[b];
            end
        end
        if (issue) begin
            ctl_d.issued = ctl_q.issued + 1'b1;
        end
        if (|bank_cmp) begin
            ctl_d.left = ctl_q.left - 1'b1;
        end
        if (ctl_q.active && ctl_q.left == '0) begin
            ctl_d.active = 1'b0;
            ctl_d.done   = 1'b1;
        end
        if (start_ok) begin
            if (eff_len == '0) begin
                ctl_d.done = 1'b1;
            end else begin
                ctl_d.active = 1'b1;
                ctl_d.len    = eff_len;
                ctl_d.issued = '0;
                ctl_d.left   = eff_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy     = ctl_q.active;
    assign mem_req  = issue;
    assign wr_valid = ctl_q.wr_valid;
    assign wr_idx   = ctl_q.wr_idx;
    assign wr_data  = ctl_q.wr_data;
    assign done     = ctl_q.done;

    // R2: requests only while a transfer runs
    assert_req_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R5: banks finish one at a time
    assert_single_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_cmp));

    // R6: never more than the register capacity issued
    assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.issued <= LEN_W'(MAX_LEN));

    // R7: done follows a write-back or an empty start
    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_valid) || $past(start && vlen == '0)));

    // R8: empty transfer finishes at once without access
    assert_empty_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vlen == '0) |=> (done && !mem_req));

    // R9: a start during a transfer leaves its length untouched
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (ctl_q.len == $past(ctl_q.len)));
endmodule

// File: tb/strided_vload_bench.sv
module strided_vload_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] stride = '0;
    logic [6:0]  vlen = '0;
    logic        busy, mem_req, wr_valid, done;
    logic [31:0] mem_addr, mem_rdata, wr_data;
    logic [5:0]  wr_idx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction
    assign mem_rdata = memf(mem_addr);

    strided_vload u_strided_vload (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .stride(stride), .vlen(vlen), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wr_valid(wr_valid),
        .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
    );

    // observation log, sampled at the falling edge
    int          n_iss, n_wb, done_cyc, n_done;
    int          iss_cyc [128];
    logic [31:0] iss_addr [128];
    int          wb_cyc [128];
    int          wb_idx [128];
    logic [31:0] wb_data [128];
    logic        busy_at_done;

    always @(negedge clk) begin
        if (mem_req && n_iss < 128) begin
            iss_cyc[n_iss] = cyc; iss_addr[n_iss] = mem_addr; n_iss++;
        end
        if (wr_valid && n_wb < 128) begin
            wb_cyc[n_wb] = cyc; wb_idx[n_wb] = int'(wr_idx); wb_data[n_wb] = wr_data; n_wb++;
        end
        if (done) begin
            if (done_cyc < 0) begin done_cyc = cyc; busy_at_done = busy; end
            n_done++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input string req, input logic [31:0] b, input logic [31:0] s,
                            input int vl, input bit poke);
        int n, sc, guard, last;
        int free_at [16];
        int exp_iss [64];
        logic [31:0] a;
        bit ok_addr, ok_iss, ok_wb;
        n = (vl > 64) ? 64 : vl;
        @(negedge clk);
        n_iss = 0; n_wb = 0; n_done = 0; done_cyc = -1;
        start = 1'b1; base_addr = b; stride = s; vlen = 7'(vl); sc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (n > 0) chk(busy === 1'b1, "R7", "busy after start", longint'(busy), 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1; base_addr = b + 32'h1000; stride = 32'd5; vlen = 7'd3;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done_cyc < 0 && guard < 3000) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
        chk(done_cyc >= 0, "R7", "done seen", longint'(done_cyc), 1);
        // reference schedule from the bank rules
        for (int k = 0; k < 16; k++) free_at[k] = 0;
        last = sc;
        for (int i = 0; i < n; i++) begin
            a = b + 32'(i) * s;
            exp_iss[i] = (last + 1 > free_at[a[3:0]]) ? last + 1 : free_at[a[3:0]];
            free_at[a[3:0]] = exp_iss[i] + 11;
            last = exp_iss[i];
        end
        chk(n_iss == n, req, "request count", n_iss, n);
        chk(n_wb == n, req, "write-back count", n_wb, n);
        chk(n_done == 1, "R7", "done pulses", n_done, 1);
        ok_addr = 1; ok_iss = 1; ok_wb = 1;
        for (int i = 0; i < n && i < n_iss && i < n_wb; i++) begin
            a = b + 32'(i) * s;
            if (ok_addr && iss_addr[i] !== a) begin
                ok_addr = 0; chk(0, "R1", $sformatf("addr of elem %0d", i), iss_addr[i], a);
            end
            if (ok_iss && iss_cyc[i] != exp_iss[i]) begin
                ok_iss = 0; chk(0, req, $sformatf("issue cycle of elem %0d", i),
                                iss_cyc[i] - sc, exp_iss[i] - sc);
            end
            if (ok_wb && (wb_idx[i] != i || wb_cyc[i] != exp_iss[i] + 11 || wb_data[i] !== memf(a))) begin
                ok_wb = 0; chk(0, "R4 R5", $sformatf("write-back %0d idx/cycle", i),
                               longint'(wb_idx[i]) * 1000 + (wb_cyc[i] - sc),
                               longint'(i) * 1000 + (exp_iss[i] + 11 - sc));
            end
        end
        chk(ok_addr, "R1", "addresses", ok_addr, 1);
        chk(ok_iss, req, "issue schedule", ok_iss, 1);
        chk(ok_wb, "R4", "write-back data and timing", ok_wb, 1);
        if (n == 0) chk(done_cyc == sc + 1, "R8", "empty done cycle", done_cyc - sc, 1);
        else chk(done_cyc == last + 12, "R7", "done cycle", done_cyc - sc, last + 12 - sc);
        chk(busy_at_done === 1'b0, "R7", "busy low at done", longint'(busy_at_done), 0);
    endtask

    task automatic t_reset_R10();
        @(negedge clk);
        chk(!busy && !mem_req && !wr_valid && !done, "R10", "idle outputs after reset",
            {busy, mem_req, wr_valid, done}, 0);
    endtask

    task automatic t_unit_stride_R2();
        run_case("R2", 32'h100, 32'd1, 20, 0);
        chk(iss_cyc[19] - iss_cyc[0] == 19, "R2", "back-to-back span", iss_cyc[19] - iss_cyc[0], 19);
    endtask

    task automatic t_same_bank_R3();
        run_case("R3", 32'h40, 32'd16, 4, 0);
        chk(iss_cyc[1] - iss_cyc[0] == 11, "R3", "same-bank spacing", iss_cyc[1] - iss_cyc[0], 11);
    endtask

    task automatic t_mixed_R3();
        run_case("R3", 32'h7, 32'd2, 20, 0);
        run_case("R3", 32'h33, 32'd0, 3, 0);
        run_case("R1", 32'h5, 32'hFFFF_FFFF, 10, 0);
    endtask

    task automatic t_saturate_R6();
        run_case("R6", 32'h5, 32'd1, 100, 0);
        chk(n_wb == 64 && wb_idx[63] == 63, "R6", "last index", wb_idx[63], 63);
    endtask

    task automatic t_empty_R8();
        run_case("R8", 32'h20, 32'd1, 0, 0);
    endtask

    task automatic t_start_busy_R9();
        run_case("R9", 32'h200, 32'd3, 24, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_R10();
        t_unit_stride_R2();
        t_same_bank_R3();
        t_mixed_R3();
        t_saturate_R6();
        t_empty_R8();
        t_start_busy_R9();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule